// File: doc/BRIEF.md
# Synchronous charge-balance frequency generator

This block is a digital model of a clocked voltage-to-frequency converter. An unsigned input code stands for the ratio of the input voltage to the reference: zero is zero-scale and 2^CODE_W would be full-scale. On every conversion tick an accumulator acting as a charge-balance integrator adds a fixed offset charge plus eight times the code. When the total reaches a modulus of ten full-scale units, a comparator-style decision removes one modulus and flags an output pulse. The average pulse rate is therefore one tenth of the tick rate plus eight tenths of the tick rate scaled by the input fraction.

The block runs on a system clock at twice the conversion rate. `tick_en` is high on alternate cycles and marks the rising edge of the conversion clock. A pulse on `fout` occupies exactly the one system cycle that follows the tick edge, which models the high phase of the conversion clock. Its width never depends on the code. The code passes through two tick-clocked stages before it reaches the accumulator, so a step at the input takes effect two ticks later. If no tick arrives for `PD_CYCLES` system cycles, the block powers down: `fout` is forced high and the accumulator clears. The next tick resumes operation from an empty accumulator.

Top module: `cbal_freq_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accumulator wrap, `fout` is low. Reset clears the accumulator and both input stages.
- R2: On each system-clock edge with `tick_en` high, the accumulator adds 2^CODE_W + 8·code, using the code held in the second input stage. If the sum is at least 10·2^CODE_W, it keeps the sum minus that modulus and `fout` is high for the following cycle. Otherwise it keeps the sum and `fout` is low.
- R3: Code 0 gives one pulse every 10 ticks. Starting from a cleared accumulator, the first pulse is on tick 10.
- R4: Code 2^(CODE_W-1), half-scale, gives a pulse on every second tick.
- R5: Code 2^(CODE_W-3), one-eighth scale, gives a pulse on every fifth tick.
- R6: Code 2^(CODE_W-2), quarter-scale, gives 3 pulses per 10 ticks. The gap between pulses is 3 or 4 ticks, and both gap lengths occur.
- R7: A pulse lasts one system cycle. After any edge with `tick_en` low, `fout` is low unless the block is in power-down.
- R8: A code change presented before tick k first enters the accumulator on tick k+2.
- R9: After PD_CYCLES consecutive edges with `tick_en` low, `fout` goes high and stays high until the next tick. After PD_CYCLES-1 such edges it is still low.
- R10: Power-down clears the accumulator. The first tick after power-down resumes normal accumulation from zero.
- R11: The largest code, 2^CODE_W-1, gives 89 or 90 pulses in any 100 ticks when CODE_W is 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at twice the conversion rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Conversion tick, high on the cycle of a conversion-clock rising edge |
| code_in | input | CODE_W | Unsigned input fraction of full-scale |
| fout | output | 1 | Frequency output pulse train; high in power-down |

## Verification
A pulse decided on a tick edge appears on `fout` during the system cycle right after that edge. It is low again one cycle later, so the bench reads `fout` at the falling edge of the cycle after each tick, and once more one cycle after that. A code step changes the rate only from the second tick after it, so rate windows start after two settling ticks. The power-down level is due right after the PD_CYCLES-th idle edge, and the bench probes one edge before that and then on that edge itself. A behavioural integer model updated on rising edges is compared with `fout` at every falling edge, with inputs driven only at falling edges.

// File: rtl/cbal_freq_gen.sv
module cbal_freq_gen #(
  parameter int CODE_W    = 8,
  parameter int PD_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] code_in,
  output logic              fout
);
  localparam int ACC_W  = CODE_W + 5;
  localparam int IDLE_W = $clog2(PD_CYCLES + 1);
  localparam logic [ACC_W-1:0] UNIT    = ACC_W'(1)  << CODE_W;
  localparam logic [ACC_W-1:0] MODULUS = ACC_W'(10) << CODE_W;

  logic [CODE_W-1:0] stg1_q, stg2_q;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  sum;
  logic [IDLE_W-1:0] idle_q;
  logic              pd_q;
  logic              wrap;
  logic              idle_done;

  assign sum       = acc_q + UNIT + (ACC_W'(stg2_q) << 3);
  assign wrap      = sum >= MODULUS;
  assign idle_done = idle_q == IDLE_W'(PD_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
      acc_q  <= '0;
      idle_q <= '0;
      pd_q   <= 1'b0;
      fout   <= 1'b0;
    end else if (tick_en) begin
      stg1_q <= code_in;
      stg2_q <= stg1_q;
      acc_q  <= wrap ? sum - MODULUS : sum;
      fout   <= wrap;
      idle_q <= '0;
      pd_q   <= 1'b0;
    end else if (!pd_q && idle_done) begin
      pd_q  <= 1'b1;
      acc_q <= '0;
      fout  <= 1'b1;
    end else begin
      if (!pd_q) idle_q <= idle_q + 1'b1;
      fout <= pd_q;
    end
  end

  a_r2_acc_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < MODULUS);

  a_r7_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> (!fout || pd_q));

  a_r9_pd_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> fout);

  a_r10_pd_clears_acc: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> acc_q == '0);

  a_r10_tick_leaves_pd: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> !pd_q);
endmodule

// File: tb/cbal_freq_gen_tb_top.sv
`timescale 1ns/1ps
module cbal_freq_gen_tb_top;
  localparam int N   = 8;
  localparam int PD  = 64;
  localparam int U   = 1 << N;
  localparam int MOD = 10 * U;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b0;
  logic [N-1:0] code_in = '0;
  logic         fout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  cbal_freq_gen #(.CODE_W(N), .PD_CYCLES(PD)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .code_in(code_in), .fout(fout));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, integers only
  int m_acc = 0, m_s1 = 0, m_s2 = 0, m_idle = 0, m_pd = 0, m_fout = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_s1 = 0; m_s2 = 0; m_idle = 0; m_pd = 0; m_fout = 0;
    end else if (tick_en) begin
      int total;
      total = m_acc + U + 8 * m_s2;
      m_s2 = m_s1;
      m_s1 = int'(code_in);
      if (total >= MOD) begin m_acc = total - MOD; m_fout = 1; end
      else begin m_acc = total; m_fout = 0; end
      m_pd = 0; m_idle = 0;
    end else if (m_pd == 0 && m_idle == PD - 1) begin
      m_pd = 1; m_acc = 0; m_fout = 1;
    end else begin
      if (m_pd == 0) m_idle++;
      m_fout = m_pd;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done)
      check(fout === m_fout[0], m_pd != 0 ? "R9 model" : "R2 model", int'(fout), m_fout);
  end

  int tick_no = 0;
  int last_pulse = -1;
  int gap_min, gap_max;

  // entered just after a falling edge; returns just after a falling edge
  task automatic one_tick(output bit p);
    tick_en = 1'b1;
    @(negedge clk);
    p = fout;
    tick_no++;
    if (p) begin
      if (last_pulse >= 0) begin
        if (tick_no - last_pulse < gap_min) gap_min = tick_no - last_pulse;
        if (tick_no - last_pulse > gap_max) gap_max = tick_no - last_pulse;
      end
      last_pulse = tick_no;
    end
    tick_en = 1'b0;
    @(negedge clk);
    check(fout === 1'b0, "R7 pulse width", int'(fout), 0);
  endtask

  task automatic run_ticks(input int n, output int cnt);
    bit p;
    cnt = 0; last_pulse = -1; gap_min = 1000; gap_max = 0;
    for (int i = 0; i < n; i++) begin
      one_tick(p);
      if (p) cnt++;
    end
  endtask

  task automatic idle(input int n);
    tick_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", 0, 1);
    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int cnt;
    bit p;
    repeat (3) @(negedge clk);
    check(fout === 1'b0, "R1 in reset", int'(fout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fout === 1'b0, "R1 after release", int'(fout), 0);

    // R3 / R1: zero code from cleared state, first pulse at tick 10
    for (int i = 1; i <= 10; i++) begin
      one_tick(p);
      check(p == (i == 10), i == 10 ? "R3 first pulse" : "R1 no early pulse", int'(p), int'(i == 10));
    end
    run_ticks(20, cnt);
    check(cnt == 2, "R3 zero-scale rate", cnt, 2);
    check(gap_min == 10 && gap_max == 10, "R3 zero-scale gap", gap_min, 10);

    // R9: boundary of the idle timeout (one idle edge already passed)
    idle(PD - 2);
    check(fout === 1'b0, "R9 not before timeout", int'(fout), 0);
    idle(1);
    check(fout === 1'b1, "R9 power-down high", int'(fout), 1);
    idle(10);
    check(fout === 1'b1, "R9 stays high", int'(fout), 1);

    // R8 + R10: half-scale step after power-down; old code still in stages
    code_in = N'(U / 2);
    for (int i = 1; i <= 4; i++) begin
      one_tick(p);
      check(p == (i == 4), "R8 settling two ticks", int'(p), int'(i == 4));
      code_in = N'(U / 2);
    end
    run_ticks(20, cnt);
    check(cnt == 10, "R4 half-scale rate", cnt, 10);
    check(gap_min == 2 && gap_max == 2, "R4 half-scale gap", gap_max, 2);

    // R5: one-eighth scale
    code_in = N'(U / 8);
    run_ticks(2, cnt);
    run_ticks(40, cnt);
    check(cnt == 8, "R5 eighth-scale rate", cnt, 8);
    check(gap_min == 5 && gap_max == 5, "R5 eighth-scale gap", gap_min, 5);

    // R6: quarter scale
    code_in = N'(U / 4);
    run_ticks(2, cnt);
    run_ticks(40, cnt);
    check(cnt == 12, "R6 quarter-scale rate", cnt, 12);
    check(gap_min == 3, "R6 short gap", gap_min, 3);
    check(gap_max == 4, "R6 long gap", gap_max, 4);

    // R10: power-down then resume with settled quarter code from zero
    idle(PD + 3);
    check(fout === 1'b1, "R9 second power-down", int'(fout), 1);
    for (int i = 1; i <= 7; i++) begin
      one_tick(p);
      check(p == (i == 4 || i == 7), "R10 resume from zero", int'(p), int'(i == 4 || i == 7));
    end

    // R11: largest code
    code_in = N'(U - 1);
    run_ticks(2, cnt);
    run_ticks(100, cnt);
    check(cnt >= 89 && cnt <= 90, "R11 max-code rate", cnt, 90);

    // R1: reset in mid-run
    tick_en = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check(fout === 1'b0, "R1 mid-run reset", int'(fout), 0);
    tick_en = 1'b0;
    code_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 1; i <= 10; i++) begin
      one_tick(p);
      check(p == (i == 10), "R1 cleared by reset", int'(p), int'(i == 10));
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule